// File: doc/BRIEF.md
# Clock Parent and Divider Solver

This block picks clock settings for a peripheral clock whose path is a parent multiplexer, a programmable integer divider and a fixed divide-by-two stage. A requester presents a target output frequency in Hz together with a one-cycle start strobe. The block then tries each candidate parent frequency from a fixed list, one after another. For each parent it finds the smallest divider that keeps the divided clock at or below twice the target, which is the rate at the input of the halving stage. Among the candidates whose divider fits the divider field, it keeps the one that gives the highest rate.

The result is a one-cycle `valid_o` pulse carrying the multiplexer code, the divider field value, the final output rate after halving, and an error flag. The result stays on the outputs until the next request completes. The block only computes these settings. Software or a sequencer writes them to the clock hardware.

A single sequential restoring divider does all the arithmetic. It performs two divisions per parent: a ceiling quotient to find the divider, then the parent rate over that divider to find the achieved rate. The controller has seven states:

- `ST_IDLE`: waits for a start. On a nonzero target it goes to `ST_CEIL_GO`. On a zero target it goes straight to `ST_DONE`.
- `ST_CEIL_GO`: launches the ceiling division.
- `ST_CEIL_WAIT`: on division done, goes to `ST_RATE_GO` if the divider fits, otherwise to `ST_NEXT`.
- `ST_RATE_GO`: launches the rate division.
- `ST_RATE_WAIT`: on division done, offers the candidate and goes to `ST_NEXT`.
- `ST_NEXT`: goes to `ST_DONE` after the last parent, otherwise to `ST_CEIL_GO`.
- `ST_DONE`: presents the result and returns to `ST_IDLE`.

Top module: `clk_parent_solver`

## Requirements
- R1: Parents are tried in the fixed order 400 000 000 Hz (mux code 0), 576 000 000 Hz (mux code 1), then 24 000 000 Hz (mux code 2). `mux_o` reports the code of the winning parent.
- R2: The search runs on twice the requested target. The rate reported on `rate_o` is floor(parent / div) / 2 (integer halving), so it never exceeds the requested target.
- R3: For each parent the divider is div = ceil(parent / (2 × target)).
- R4: A parent is skipped when div − 1 exceeds 2^DIV_W − 1 (127 by default). A divider of exactly 2^DIV_W is still accepted.
- R5: A parent replaces the best so far only if floor(parent / div) is strictly greater than the best rate. On a tie the earlier parent in the order is kept.
- R6: `div_field_o` equals div − 1 of the winning parent.
- R7: If no parent is representable, the result has `err_o` = 1, `rate_o` = 0, `mux_o` = 0 and `div_field_o` = 0.
- R8: A start with a target of zero produces `valid_o` in the cycle right after the start edge, with `err_o` = 1 and all other result fields at 0.
- R9: A start that arrives while `busy_o` is high is ignored. The running request completes with its own target.
- R10: `valid_o` is high for exactly one cycle per accepted request. The result fields change only in that cycle and hold their values until the next result.
- R11: After reset, `valid_o`, `busy_o`, `err_o`, `rate_o`, `mux_o` and `div_field_o` are all 0.
- R12: Targets up to 2^32 − 1 are handled without overflow when the target is doubled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe; accepted only while idle |
| target_i | input | RATE_W | Requested output rate in Hz |
| busy_o | output | 1 | A request is in progress |
| valid_o | output | 1 | One-cycle result strobe |
| mux_o | output | SEL_W | Chosen parent mux code |
| div_field_o | output | DIV_W | Divider minus one |
| rate_o | output | RATE_W | Achieved output rate in Hz after halving |
| err_o | output | 1 | No usable setting, or the target was zero |

## Verification
The hardest situations to reach from the ports are the narrow edges of the divider field and the tie between parents. Two things have to line up: the ceiling quotient must land exactly on 2^DIV_W or just above it, and two parents must divide down to the same rate. The stimulus table therefore uses targets computed backwards from the parent rates. A target of 93 750 Hz drives the 24 MHz parent to a divider of exactly 128. A target of 93 023 Hz needs 130, so every parent is rejected. A target of 12 MHz makes the 576 MHz and 24 MHz parents meet at the same 24 MHz rate, which shows that the earlier parent wins. Directed tests then inject a second start in the middle of a search and a zero target.

// File: rtl/cps_pkg.sv
package cps_pkg;

    // Controller states of the solver sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CEIL_GO,
        ST_CEIL_WAIT,
        ST_RATE_GO,
        ST_RATE_WAIT,
        ST_NEXT,
        ST_DONE
    } cps_state_e;

endpackage

// File: rtl/cps_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
module cps_divider #(
    parameter int N = 32,   // dividend / quotient width
    parameter int D = 33    // divisor / remainder width
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [D-1:0] divisor,
    output logic         done,
    output logic [N-1:0] quot,
    output logic [D-1:0] rem
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] STEPS = CW'(N);

    logic [D:0]    acc_q;
    logic [N-1:0]  q_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [D-1:0]  dsr_q;
    logic [D:0]    shifted;
    logic [D:0]    diff;

    // Partial remainder with the next dividend bit shifted in, and trial subtraction.
    assign shifted = {acc_q[D-1:0], q_q[N-1]};
    assign diff    = shifted - {1'b0, dsr_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            q_q   <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
            dsr_q <= '0;
        end else if (start) begin
            acc_q <= '0;
            q_q   <= dividend;
            dsr_q <= divisor;
            cnt_q <= STEPS;
            run_q <= 1'b1;
            done  <= 1'b0;
        end else if (run_q) begin
            acc_q <= diff[D] ? shifted : diff;
            q_q   <= {q_q[N-2:0], ~diff[D]};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == {{(CW-1){1'b0}}, 1'b1}) begin
                run_q <= 1'b0;
                done  <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quot = q_q;
    assign rem  = acc_q[D-1:0];

endmodule

// File: rtl/cps_parent_table.sv
// Candidate parent list, unpacked from packed parameters and indexed.
module cps_parent_table #(
    parameter int NUM_PAR = 3,
    parameter int RATE_W  = 32,
    parameter int SEL_W   = 2,
    parameter int IDX_W   = 2,
    parameter logic [NUM_PAR*RATE_W-1:0] PAR_RATES = '0,
    parameter logic [NUM_PAR*SEL_W-1:0]  PAR_CODES = '0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [RATE_W-1:0] rate,
    output logic [SEL_W-1:0]  code
);
    logic [RATE_W-1:0] rate_arr [NUM_PAR];
    logic [SEL_W-1:0]  code_arr [NUM_PAR];

    for (genvar g = 0; g < NUM_PAR; g++) begin : g_entry
        assign rate_arr[g] = PAR_RATES[g*RATE_W +: RATE_W];
        assign code_arr[g] = PAR_CODES[g*SEL_W +: SEL_W];
    end

    always_comb begin
        rate = '0;
        code = '0;
        for (int i = 0; i < NUM_PAR; i++) begin
            if (idx == IDX_W'(i)) begin
                rate = rate_arr[i];
                code = code_arr[i];
            end
        end
    end

endmodule

// File: rtl/cps_best_keeper.sv
// Holds the best candidate so far; replaces only on a strictly higher rate.
module cps_best_keeper #(
    parameter int RATE_W = 32,
    parameter int SEL_W  = 2,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              offer,
    input  logic [RATE_W-1:0] offer_rate,
    input  logic [SEL_W-1:0]  offer_code,
    input  logic [DIV_W-1:0]  offer_field,
    output logic [RATE_W-1:0] best_rate,
    output logic [SEL_W-1:0]  best_code,
    output logic [DIV_W-1:0]  best_field,
    output logic              found
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_rate  <= '0;
            best_code  <= '0;
            best_field <= '0;
            found      <= 1'b0;
        end else if (clear) begin
            best_rate  <= '0;
            best_code  <= '0;
            best_field <= '0;
            found      <= 1'b0;
        end else if (offer && (offer_rate > best_rate)) begin
            best_rate  <= offer_rate;
            best_code  <= offer_code;
            best_field <= offer_field;
            found      <= 1'b1;
        end
    end

endmodule

// File: rtl/clk_parent_solver.sv
module clk_parent_solver
    import cps_pkg::*;
#(
    parameter int RATE_W  = 32,
    parameter int DIV_W   = 7,
    parameter int NUM_PAR = 3,
    parameter int SEL_W   = 2,
    // Entry 0 is tried first.
    parameter logic [NUM_PAR*RATE_W-1:0] PAR_RATES =
        {32'd24_000_000, 32'd576_000_000, 32'd400_000_000},
    parameter logic [NUM_PAR*SEL_W-1:0]  PAR_CODES = {2'd2, 2'd1, 2'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RATE_W-1:0] target_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [SEL_W-1:0]  mux_o,
    output logic [DIV_W-1:0]  div_field_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              err_o
);
    localparam int TGT_W = RATE_W + 1;
    localparam int IDX_W = (NUM_PAR > 1) ? $clog2(NUM_PAR) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAR - 1);
    localparam logic [RATE_W:0]  DIV_LIMIT = {{RATE_W{1'b0}}, 1'b1} << DIV_W;

    cps_state_e st_q, st_d;

    logic [TGT_W-1:0]  tgt2_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DIV_W:0]    cand_div_q;
    logic [DIV_W:0]    cand_m1;

    logic [RATE_W-1:0] par_rate;
    logic [SEL_W-1:0]  par_code;

    logic              dv_start, dv_done;
    logic [TGT_W-1:0]  dv_divisor;
    logic [RATE_W-1:0] dv_quot;
    logic [TGT_W-1:0]  dv_rem;

    logic [RATE_W:0]   div_val;
    logic              div_fits;
    logic              accept;

    logic [RATE_W-1:0] best_rate;
    logic [SEL_W-1:0]  best_code;
    logic [DIV_W-1:0]  best_field;
    logic              found;

    assign accept = (st_q == ST_IDLE) && start_i;
    assign busy_o = (st_q != ST_IDLE);

    // Parent candidates
    cps_parent_table #(
        .NUM_PAR  (NUM_PAR),
        .RATE_W   (RATE_W),
        .SEL_W    (SEL_W),
        .IDX_W    (IDX_W),
        .PAR_RATES(PAR_RATES),
        .PAR_CODES(PAR_CODES)
    ) u_table (
        .idx (idx_q),
        .rate(par_rate),
        .code(par_code)
    );

    // Shared divider: ceiling step divides by the doubled target,
    // rate step divides by the chosen divider.
    assign dv_start   = (st_q == ST_CEIL_GO) || (st_q == ST_RATE_GO);
    assign dv_divisor = (st_q == ST_RATE_GO)
                      ? {{(TGT_W-DIV_W-1){1'b0}}, cand_div_q}
                      : tgt2_q;

    cps_divider #(
        .N(RATE_W),
        .D(TGT_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dv_start),
        .dividend(par_rate),
        .divisor (dv_divisor),
        .done    (dv_done),
        .quot    (dv_quot),
        .rem     (dv_rem)
    );

    // Ceiling quotient and field-fit test
    assign div_val  = {1'b0, dv_quot} + {{RATE_W{1'b0}}, (|dv_rem)};
    assign div_fits = (div_val <= DIV_LIMIT);
    assign cand_m1  = cand_div_q - {{DIV_W{1'b0}}, 1'b1};

    cps_best_keeper #(
        .RATE_W(RATE_W),
        .SEL_W (SEL_W),
        .DIV_W (DIV_W)
    ) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .offer      ((st_q == ST_RATE_WAIT) && dv_done),
        .offer_rate (dv_quot),
        .offer_code (par_code),
        .offer_field(cand_m1[DIV_W-1:0]),
        .best_rate  (best_rate),
        .best_code  (best_code),
        .best_field (best_field),
        .found      (found)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) st_d = (target_i == '0) ? ST_DONE : ST_CEIL_GO;
            end
            ST_CEIL_GO:   st_d = ST_CEIL_WAIT;
            ST_CEIL_WAIT: begin
                if (dv_done) st_d = div_fits ? ST_RATE_GO : ST_NEXT;
            end
            ST_RATE_GO:   st_d = ST_RATE_WAIT;
            ST_RATE_WAIT: begin
                if (dv_done) st_d = ST_NEXT;
            end
            ST_NEXT:      st_d = (idx_q == LAST_IDX) ? ST_DONE : ST_CEIL_GO;
            ST_DONE:      st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Search datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt2_q     <= '0;
            idx_q      <= '0;
            cand_div_q <= '0;
        end else begin
            if (accept) begin
                tgt2_q <= {target_i, 1'b0};
                idx_q  <= '0;
            end
            if ((st_q == ST_CEIL_WAIT) && dv_done && div_fits)
                cand_div_q <= div_val[DIV_W:0];
            if ((st_q == ST_NEXT) && (idx_q != LAST_IDX))
                idx_q <= idx_q + 1'b1;
        end
    end

    // Output registers: loaded once, on entry to ST_DONE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o     <= 1'b0;
            mux_o       <= '0;
            div_field_o <= '0;
            rate_o      <= '0;
            err_o       <= 1'b0;
        end else if ((st_d == ST_DONE) && (st_q != ST_DONE)) begin
            valid_o <= 1'b1;
            if (st_q == ST_IDLE) begin
                mux_o       <= '0;
                div_field_o <= '0;
                rate_o      <= '0;
                err_o       <= 1'b1;
            end else begin
                mux_o       <= best_code;
                div_field_o <= best_field;
                rate_o      <= {1'b0, best_rate[RATE_W-1:1]};
                err_o       <= ~found;
            end
        end else begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/cps_solver_chk.sv
module cps_solver_chk #(
    parameter int RATE_W = 32,
    parameter int DIV_W  = 7,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [RATE_W-1:0] target_i,
    input logic              busy_o,
    input logic              valid_o,
    input logic [SEL_W-1:0]  mux_o,
    input logic [DIV_W-1:0]  div_field_o,
    input logic [RATE_W-1:0] rate_o,
    input logic              err_o
);
    logic [RATE_W-1:0] lat_tgt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  lat_tgt <= '0;
        else if (start_i && !busy_o) lat_tgt <= target_i;
    end

    p_not_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !err_o |-> (rate_o <= lat_tgt) && (rate_o != '0));

    p_err_zeroes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && err_o |-> (rate_o == '0) && (mux_o == '0) && (div_field_o == '0));

    p_zero_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (target_i == '0) |=> valid_o && err_o);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (target_i != '0) |=> busy_o && !valid_o);

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(rate_o) && $stable(mux_o) && $stable(div_field_o) && $stable(err_o));

endmodule

bind clk_parent_solver cps_solver_chk #(
    .RATE_W(RATE_W),
    .DIV_W (DIV_W),
    .SEL_W (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .target_i   (target_i),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .mux_o      (mux_o),
    .div_field_o(div_field_o),
    .rate_o     (rate_o),
    .err_o      (err_o)
);

// File: tb/clk_parent_solver_tb.sv
module clk_parent_solver_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] target_i = '0;
    logic        busy_o, valid_o, err_o;
    logic [1:0]  mux_o;
    logic [6:0]  div_field_o;
    logic [31:0] rate_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    clk_parent_solver u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .target_i   (target_i),
        .busy_o     (busy_o),
        .valid_o    (valid_o),
        .mux_o      (mux_o),
        .div_field_o(div_field_o),
        .rate_o     (rate_o),
        .err_o      (err_o)
    );

    typedef struct packed {
        logic [31:0] tgt;
        logic [1:0]  mux;
        logic [6:0]  fld;
        logic [31:0] rate;
        logic        err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'd50_000_000,  2'd0, 7'd3,   32'd50_000_000, 1'b0}, // R3 R6
        '{32'd48_000_000,  2'd1, 7'd5,   32'd48_000_000, 1'b0}, // R1
        '{32'd200_000_000, 2'd0, 7'd0,   32'd200_000_000,1'b0}, // R6
        '{32'd12_000_000,  2'd1, 7'd23,  32'd12_000_000, 1'b0}, // R5 tie
        '{32'd1_000_000_000,2'd1,7'd0,   32'd288_000_000,1'b0}, // R5
        '{32'd400_000,     2'd2, 7'd29,  32'd400_000,    1'b0}, // R4
        '{32'd1,           2'd0, 7'd0,   32'd0,          1'b1}, // R7
        '{32'd93_750,      2'd2, 7'd127, 32'd93_750,     1'b0}, // R4 edge
        '{32'd93_023,      2'd0, 7'd0,   32'd0,          1'b1}, // R4 R7
        '{32'd35_000_000,  2'd0, 7'd5,   32'd33_333_333, 1'b0}, // R2 R3
        '{32'hFFFF_FFFF,   2'd1, 7'd0,   32'd288_000_000,1'b0}, // R12
        '{32'd0,           2'd0, 7'd0,   32'd0,          1'b1}  // R8
    };

    function automatic string vtag(input int i);
        case (i)
            0: return "R3";
            1: return "R1";
            2: return "R6";
            3: return "R5";
            4: return "R5";
            5: return "R4";
            6: return "R7";
            7: return "R4";
            8: return "R7";
            9: return "R2";
            10: return "R12";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [31:0] t);
        @(negedge clk);
        start_i  = 1'b1;
        target_i = t;
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        int n;
        n = 0;
        while (!valid_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        got = valid_o;
    endtask

    function automatic logic [63:0] pack_res(input logic [1:0] m, input logic [6:0] f,
                                             input logic [31:0] r, input logic e);
        return {22'd0, m, f, r, e};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        bit got;
        logic [31:0] held_rate;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!valid_o && !busy_o && !err_o && rate_o == 0 && mux_o == 0 && div_field_o == 0,
              "R11", pack_res(mux_o, div_field_o, rate_o, err_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            pulse_start(VECS[i].tgt);
            wait_valid(got);
            check(got && pack_res(mux_o, div_field_o, rate_o, err_o)
                         == pack_res(VECS[i].mux, VECS[i].fld, VECS[i].rate, VECS[i].err),
                  vtag(i), pack_res(mux_o, div_field_o, rate_o, err_o),
                  pack_res(VECS[i].mux, VECS[i].fld, VECS[i].rate, VECS[i].err));
            @(negedge clk);
        end

        // R8: zero target answers in the cycle after the start edge
        pulse_start(32'd0);
        check(valid_o && err_o, "R8", {62'd0, valid_o, err_o}, 64'd3);

        // R10: one-cycle valid, result held afterwards
        pulse_start(32'd48_000_000);
        wait_valid(got);
        held_rate = rate_o;
        @(negedge clk);
        check(!valid_o, "R10", {63'd0, valid_o}, 64'd0);
        repeat (3) @(negedge clk);
        check(rate_o == held_rate && mux_o == 2'd1 && div_field_o == 7'd5, "R10",
              {32'd0, rate_o}, {32'd0, held_rate});

        // R9: second start during a search is ignored
        pulse_start(32'd50_000_000);
        repeat (5) @(negedge clk);
        start_i  = 1'b1;
        target_i = 32'd12_000_000;
        @(negedge clk);
        start_i  = 1'b0;
        wait_valid(got);
        check(got && mux_o == 2'd0 && div_field_o == 7'd3 && rate_o == 32'd50_000_000, "R9",
              pack_res(mux_o, div_field_o, rate_o, err_o),
              pack_res(2'd0, 7'd3, 32'd50_000_000, 1'b0));
        @(negedge clk);
        check(!busy_o && !valid_o, "R9", {62'd0, busy_o, valid_o}, 64'd0);

        // R7 after a good result: error clears fields
        pulse_start(32'd2);
        wait_valid(got);
        check(got && err_o && rate_o == 0 && mux_o == 0 && div_field_o == 0, "R7",
              pack_res(mux_o, div_field_o, rate_o, err_o), pack_res(2'd0, 7'd0, 32'd0, 1'b1));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule